// File: doc/BRIEF.md
# Audio Input Channel Sequencer

The sequencer gathers samples from four 18-bit converter channels and two 24-bit serial PCM channels. Each source delivers a parallel word with a one-cycle valid strobe. Converter words are widened to 24 bits. A per-converter mode bit chooses the placement: either sign-extended in the low bits, or left-aligned with zero fill below. Each source has a store-enable bit and a queue-select field. These decide whether its sample is kept, and which buffer queue receives it.

Samples are parked in one holding register per source. A single write port then drains them, one write per clock, in a fixed time order: converter 0, converter 2, converter 1, converter 3, then PCM 0, then PCM 1. Sources that share a queue therefore always appear in that order within a frame.

Converters can also be paired for dynamic range extension: 0 with 1, and 2 with 3. A paired channel yields a single sample under the lower converter's settings. That sample is the lower converter's word, unless that word sits at full scale, in which case the higher converter's word is used.

Top module: `audio_in_seq`

## Requirements
- R1: After reset, and with no strobe since, `wr_valid` stays low.
- R2: With a converter's shift bit clear, its 18-bit sample is written sign-extended to 24 bits (bit 17 copied into bits 23..18).
- R3: With a converter's shift bit set, its sample is written as the 18 bits in positions 23..6, with bits 5..0 zero.
- R4: PCM samples are written unchanged as 24-bit words.
- R5: A sample whose source has its store-enable bit clear produces no write. Sources are indexed converter 0..3 as 0..3, PCM 0 as 4 and PCM 1 as 5, and store-enable bit s belongs to source s.
- R6: `wr_queue` carries the queue field of the written sample's source, taken from bits [s*Q_W +: Q_W] of `cfg_store_q`.
- R7: Converter samples strobed in the same cycle are written one per cycle in the order 0, 2, 1, 3.
- R8: PCM 0 is written before PCM 1, and both after any converter sample pending at the same time.
- R9: With pair p's extension bit set (pair 0 = converters 0 and 1, pair 1 = converters 2 and 3), a non-full-scale lower sample is written using the lower converter's shift bit and queue. The higher converter's strobe then produces no write of its own.
- R10: With pair extension on and the lower sample at full scale (18'h1FFFF or 18'h20000), the higher converter's sample from the same cycle is written instead, still under the lower converter's shift bit and queue.
- R11: A lone sample strobed at clock edge k, with nothing else pending, appears on `wr_valid`/`wr_data` after edge k+1.
- R12: A new strobe for a source whose previous sample is still held replaces that sample, and only the newer one is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_data | input | NUM_CONV*CONV_W | Converter samples, channel c at [c*CONV_W +: CONV_W] |
| conv_valid | input | NUM_CONV | Per-converter sample strobe |
| pcm_data | input | NUM_PCM*SAMP_W | PCM samples, channel c at [c*SAMP_W +: SAMP_W] |
| pcm_valid | input | NUM_PCM | Per-PCM sample strobe |
| cfg_shift | input | NUM_CONV | Per-converter left-align mode bit |
| cfg_drx | input | NUM_CONV/2 | Per-pair range extension enable |
| cfg_store_en | input | NUM_CONV+NUM_PCM | Per-source store enable |
| cfg_store_q | input | (NUM_CONV+NUM_PCM)*Q_W | Per-source queue select |
| wr_valid | output | 1 | Queue write strobe |
| wr_queue | output | Q_W | Destination queue of the write |
| wr_data | output | SAMP_W | 24-bit sample written |

## Verification
The hardest situation to reach is a strobe for a source that arrives while its earlier sample is still waiting behind higher-priority slots. Only a burst followed at once by a second strobe produces it. The stimulus fires all four converters in one cycle, then fires converter 3 again on the very next edge, while converter 0 is being written. The scoreboard expects the drain order 0, 2, 1, 3 with only the second converter 3 value. Full-scale selection is reached by driving both extreme codes on the lower converter of each pair.

// File: rtl/aics_pkg.sv
package aics_pkg;

  // Maps drain position k to source index: even converters first, then odd
  // converters, then PCM channels in ascending order.
  function automatic int seq_source(input int k, input int nconv);
    if (k < nconv / 2)
      return 2 * k;
    else if (k < nconv)
      return 2 * (k - nconv / 2) + 1;
    else
      return k;
  endfunction

  // Position in the drain order of a given source index.
  function automatic int seq_slot(input int s, input int nconv);
    if (s >= nconv)
      return s;
    else if (s % 2 == 0)
      return s / 2;
    else
      return nconv / 2 + s / 2;
  endfunction

endpackage

// File: rtl/aics_widen.sv
module aics_widen #(
  parameter int IN_W  = 18,
  parameter int OUT_W = 24
) (
  input  logic [IN_W-1:0]  din,
  input  logic             left_align,
  output logic [OUT_W-1:0] dout
);
  localparam int PAD = OUT_W - IN_W;

  always_comb begin
    if (left_align)
      dout = {din, {PAD{1'b0}}};
    else
      dout = {{PAD{din[IN_W-1]}}, din};
  end
endmodule

// File: rtl/aics_drx_pair.sv
module aics_drx_pair #(
  parameter int IN_W = 18
) (
  input  logic            en,
  input  logic [IN_W-1:0] lo_data,
  input  logic [IN_W-1:0] hi_data,
  input  logic            lo_valid,
  input  logic            hi_valid,
  output logic [IN_W-1:0] lo_sel,
  output logic            lo_valid_o,
  output logic            hi_valid_o
);
  localparam logic [IN_W-1:0] POS_MAX = {1'b0, {(IN_W-1){1'b1}}};
  localparam logic [IN_W-1:0] NEG_MAX = {1'b1, {(IN_W-1){1'b0}}};

  logic lo_full;

  assign lo_full    = (lo_data == POS_MAX) || (lo_data == NEG_MAX);
  assign lo_sel     = (en && lo_full) ? hi_data : lo_data;
  assign lo_valid_o = lo_valid;
  assign hi_valid_o = hi_valid & ~en;
endmodule

// File: rtl/aics_hold_slot.sv
module aics_hold_slot #(
  parameter int W  = 24,
  parameter int QW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [W-1:0]  din,
  input  logic [QW-1:0] qin,
  input  logic          grant,
  output logic          pending,
  output logic [W-1:0]  dout,
  output logic [QW-1:0] qout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      dout    <= '0;
      qout    <= '0;
    end else if (load) begin
      pending <= 1'b1;
      dout    <= din;
      qout    <= qin;
    end else if (grant) begin
      pending <= 1'b0;
    end
  end

  AST_GRANT_ONLY_PENDING: assert property (@(posedge clk) disable iff (rst)
    grant |-> pending); // R7
endmodule

// File: rtl/aics_pick.sv
module aics_pick #(
  parameter int N = 6
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  // Lowest index wins: isolate the least significant set bit.
  assign gnt = req & (~req + N'(1));
endmodule

// File: rtl/audio_in_seq.sv
module audio_in_seq
  import aics_pkg::*;
#(
  parameter int NUM_CONV = 4,
  parameter int NUM_PCM  = 2,
  parameter int CONV_W   = 18,
  parameter int SAMP_W   = 24,
  parameter int NUM_Q    = 4,
  parameter int Q_W      = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NUM_CONV*CONV_W-1:0]         conv_data,
  input  logic [NUM_CONV-1:0]                conv_valid,
  input  logic [NUM_PCM*SAMP_W-1:0]          pcm_data,
  input  logic [NUM_PCM-1:0]                 pcm_valid,
  input  logic [NUM_CONV-1:0]                cfg_shift,
  input  logic [NUM_CONV/2-1:0]              cfg_drx,
  input  logic [NUM_CONV+NUM_PCM-1:0]        cfg_store_en,
  input  logic [(NUM_CONV+NUM_PCM)*Q_W-1:0]  cfg_store_q,
  output logic                               wr_valid,
  output logic [Q_W-1:0]                     wr_queue,
  output logic [SAMP_W-1:0]                  wr_data
);
  localparam int NSRC  = NUM_CONV + NUM_PCM;
  localparam int NPAIR = NUM_CONV / 2;

  logic [SAMP_W-1:0] src_data  [NSRC];
  logic [NSRC-1:0]   src_valid;

  // Converter front: pair selection, then widening.
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam int LO = 2 * p;
    localparam int HI = 2 * p + 1;
    logic [CONV_W-1:0] lo_raw;

    aics_drx_pair #(.IN_W(CONV_W)) i_pair (
      .en         (cfg_drx[p]),
      .lo_data    (conv_data[LO*CONV_W +: CONV_W]),
      .hi_data    (conv_data[HI*CONV_W +: CONV_W]),
      .lo_valid   (conv_valid[LO]),
      .hi_valid   (conv_valid[HI]),
      .lo_sel     (lo_raw),
      .lo_valid_o (src_valid[LO]),
      .hi_valid_o (src_valid[HI])
    );

    aics_widen #(.IN_W(CONV_W), .OUT_W(SAMP_W)) i_widen_lo (
      .din        (lo_raw),
      .left_align (cfg_shift[LO]),
      .dout       (src_data[LO])
    );

    aics_widen #(.IN_W(CONV_W), .OUT_W(SAMP_W)) i_widen_hi (
      .din        (conv_data[HI*CONV_W +: CONV_W]),
      .left_align (cfg_shift[HI]),
      .dout       (src_data[HI])
    );
  end

  for (genvar c = 0; c < NUM_PCM; c++) begin : g_pcm
    assign src_data[NUM_CONV+c]  = pcm_data[c*SAMP_W +: SAMP_W];
    assign src_valid[NUM_CONV+c] = pcm_valid[c];
  end

  // Holding slots, laid out in drain order.
  logic [NSRC-1:0]   pend;
  logic [NSRC-1:0]   grant;
  logic [NSRC-1:0]   slot_load;
  logic [SAMP_W-1:0] slot_data [NSRC];
  logic [Q_W-1:0]    slot_q    [NSRC];

  for (genvar k = 0; k < NSRC; k++) begin : g_slot
    localparam int S = seq_source(k, NUM_CONV);

    assign slot_load[k] = src_valid[S] & cfg_store_en[S];

    aics_hold_slot #(.W(SAMP_W), .QW(Q_W)) i_slot (
      .clk     (clk),
      .rst     (rst),
      .load    (slot_load[k]),
      .din     (src_data[S]),
      .qin     (cfg_store_q[S*Q_W +: Q_W]),
      .grant   (grant[k]),
      .pending (pend[k]),
      .dout    (slot_data[k]),
      .qout    (slot_q[k])
    );
  end

  aics_pick #(.N(NSRC)) i_pick (
    .req (pend),
    .gnt (grant)
  );

  logic [SAMP_W-1:0] mux_data;
  logic [Q_W-1:0]    mux_q;

  always_comb begin
    mux_data = '0;
    mux_q    = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (grant[k]) begin
        mux_data = mux_data | slot_data[k];
        mux_q    = mux_q | slot_q[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid <= 1'b0;
      wr_queue <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= |grant;
      wr_queue <= mux_q;
      wr_data  <= mux_data;
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R7
  AST_WRITE_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> $past(|pend)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(|pend) |=> !wr_valid); // R1
  AST_HEAD_DRAINS: assert property (@(posedge clk) disable iff (rst)
    (pend[0] && !slot_load[0]) |=> !pend[0]); // R7
endmodule

// File: tb/test_audio_in_seq.sv
module test_audio_in_seq;
  localparam int QW = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [17:0] cv [4];
  logic [23:0] pv [2];
  logic [3:0]  cvld = '0;
  logic [1:0]  pvld = '0;
  logic [3:0]  shift = '0;
  logic [1:0]  drx = '0;
  logic [5:0]  sen = '1;
  logic [11:0] sq = '0;
  logic        wr_valid;
  logic [1:0]  wr_queue;
  logic [23:0] wr_data;

  int checks = 0;
  int errors = 0;
  int unexp  = 0;
  string cur_req = "R1";

  logic [1:0]  exp_q [$];
  logic [23:0] exp_d [$];
  string       exp_r [$];

  always #10 clk = ~clk;

  audio_in_seq i_audio_in_seq (
    .clk          (clk),
    .rst          (rst),
    .conv_data    ({cv[3], cv[2], cv[1], cv[0]}),
    .conv_valid   (cvld),
    .pcm_data     ({pv[1], pv[0]}),
    .pcm_valid    (pvld),
    .cfg_shift    (shift),
    .cfg_drx      (drx),
    .cfg_store_en (sen),
    .cfg_store_q  (sq),
    .wr_valid     (wr_valid),
    .wr_queue     (wr_queue),
    .wr_data      (wr_data)
  );

  function automatic logic [23:0] widen(input logic [17:0] x, input logic sh);
    return sh ? {x, 6'b0} : {{6{x[17]}}, x};
  endfunction

  function automatic logic [1:0] qof(input int s);
    return sq[s*QW +: QW];
  endfunction

  task automatic expect_item(input logic [1:0] q, input logic [23:0] d, input string r);
    exp_q.push_back(q);
    exp_d.push_back(d);
    exp_r.push_back(r);
  endtask

  task automatic pulse();
    @(posedge clk);
    @(negedge clk);
    cvld = '0;
    pvld = '0;
  endtask

  task automatic drain_check(input string r);
    repeat (10) @(negedge clk);
    checks++;
    if (exp_d.size() != 0 || unexp != 0) begin
      errors++;
      $display("FAIL %s: left=%0d unexpected=%0d, expected left=0 unexpected=0",
               r, exp_d.size(), unexp);
    end
    exp_q.delete();
    exp_d.delete();
    exp_r.delete();
    unexp = 0;
  endtask

  // Monitor: compare each write against the head of the scoreboard.
  always @(negedge clk) begin
    if (!rst && wr_valid) begin
      checks++;
      if (exp_d.size() == 0) begin
        errors++;
        unexp++;
        $display("FAIL %s: unexpected write q=%0d d=%h, expected no write",
                 cur_req, wr_queue, wr_data);
      end else begin
        logic [1:0]  eq;
        logic [23:0] ed;
        string       er;
        eq = exp_q.pop_front();
        ed = exp_d.pop_front();
        er = exp_r.pop_front();
        if (wr_queue !== eq || wr_data !== ed) begin
          errors++;
          $display("FAIL %s: got q=%0d d=%h, expected q=%0d d=%h",
                   er, wr_queue, wr_data, eq, ed);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) cv[i] = '0;
    for (int i = 0; i < 2; i++) pv[i] = '0;
    for (int s = 0; s < 6; s++) sq[s*QW +: QW] = QW'(s % 4);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    cur_req = "R1";
    checks++;
    if (wr_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: wr_valid=%b, expected 0", wr_valid);
    end
    drain_check("R1");

    // R2: sign extension
    cur_req = "R2";
    cv[0] = 18'h20001; cvld = 4'b0001;
    expect_item(qof(0), 24'hFE0001, "R2");
    pulse();
    cv[1] = 18'h0ABCD; cvld = 4'b0010;
    expect_item(qof(1), 24'h00ABCD, "R2");
    pulse();
    drain_check("R2");

    // R3: left alignment
    cur_req = "R3";
    shift = 4'b1111;
    cv[1] = 18'h12345; cvld = 4'b0010;
    expect_item(qof(1), {18'h12345, 6'b0}, "R3");
    pulse();
    cv[2] = 18'h3FFFF; cvld = 4'b0100;
    expect_item(qof(2), 24'hFFFFC0, "R3");
    pulse();
    drain_check("R3");
    shift = 4'b0000;

    // R4: PCM pass-through
    cur_req = "R4";
    pv[1] = 24'hA5C3E1; pvld = 2'b10;
    expect_item(qof(5), 24'hA5C3E1, "R4");
    pulse();
    drain_check("R4");

    // R5: store disabled source is dropped
    cur_req = "R5";
    sen = 6'b111011;
    cv[2] = 18'h01111; cvld = 4'b0100;
    pulse();
    drain_check("R5");
    sen = '1;

    // R6 and R7: four converters at once with distinct queues
    cur_req = "R7";
    sq = {2'd0, 2'd1, 2'd0, 2'd2, 2'd1, 2'd3};
    for (int i = 0; i < 4; i++) cv[i] = 18'(18'h00100 * (i + 1));
    cvld = 4'b1111;
    expect_item(qof(0), widen(cv[0], 1'b0), "R7 R6 conv0");
    expect_item(qof(2), widen(cv[2], 1'b0), "R7 R6 conv2");
    expect_item(qof(1), widen(cv[1], 1'b0), "R7 R6 conv1");
    expect_item(qof(3), widen(cv[3], 1'b0), "R7 R6 conv3");
    pulse();
    drain_check("R7");

    // R8: all six sources in one cycle
    cur_req = "R8";
    for (int i = 0; i < 4; i++) cv[i] = 18'(18'h01010 + i);
    pv[0] = 24'h111111; pv[1] = 24'h222222;
    cvld = 4'b1111; pvld = 2'b11;
    expect_item(qof(0), widen(cv[0], 1'b0), "R8");
    expect_item(qof(2), widen(cv[2], 1'b0), "R8");
    expect_item(qof(1), widen(cv[1], 1'b0), "R8");
    expect_item(qof(3), widen(cv[3], 1'b0), "R8");
    expect_item(qof(4), pv[0], "R8 pcm0");
    expect_item(qof(5), pv[1], "R8 pcm1");
    pulse();
    drain_check("R8");

    // R9: extension pair, lower sample in range; higher strobe silent
    cur_req = "R9";
    drx = 2'b01;
    shift = 4'b0010;
    cv[0] = 18'h01234; cv[1] = 18'h05555; cvld = 4'b0011;
    expect_item(qof(0), widen(18'h01234, 1'b0), "R9");
    pulse();
    cv[1] = 18'h06666; cvld = 4'b0010;
    pulse();
    drain_check("R9");

    // R10: lower sample at positive and negative full scale
    cur_req = "R10";
    drx = 2'b11;
    shift = 4'b0100;
    cv[0] = 18'h1FFFF; cv[1] = 18'h00ABC; cvld = 4'b0011;
    expect_item(qof(0), widen(18'h00ABC, 1'b0), "R10 pair0");
    pulse();
    cv[2] = 18'h20000; cv[3] = 18'h30000; cvld = 4'b1100;
    expect_item(qof(2), widen(18'h30000, 1'b1), "R10 pair1");
    pulse();
    drain_check("R10");
    drx = 2'b00;
    shift = 4'b0000;

    // R11: latency of a lone sample
    cur_req = "R11";
    pv[0] = 24'h0F0F0F; pvld = 2'b01;
    expect_item(qof(4), 24'h0F0F0F, "R11");
    pulse();
    checks++;
    if (wr_valid !== 1'b0) begin
      errors++;
      $display("FAIL R11: wr_valid=%b one edge after strobe, expected 0", wr_valid);
    end
    @(negedge clk);
    checks++;
    if (wr_valid !== 1'b1) begin
      errors++;
      $display("FAIL R11: wr_valid=%b two edges after strobe, expected 1", wr_valid);
    end
    drain_check("R11");

    // R12: re-strobe of a held source replaces its sample
    cur_req = "R12";
    for (int i = 0; i < 4; i++) cv[i] = 18'(18'h02000 + i);
    cvld = 4'b1111;
    expect_item(qof(0), widen(18'h02000, 1'b0), "R12");
    expect_item(qof(2), widen(18'h02002, 1'b0), "R12");
    expect_item(qof(1), widen(18'h02001, 1'b0), "R12");
    expect_item(qof(3), widen(18'h0BEEF, 1'b0), "R12 newer");
    pulse();
    cv[3] = 18'h0BEEF; cvld = 4'b1000;
    pulse();
    drain_check("R12");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule